// File: doc/BRIEF.md
# Byte-Count Buffered Transfer Controller

This block owns a small byte buffer that sits between a host data port and a bit-level serial engine. A transfer has a programmed length. For a transmit, the host first fills the buffer through a byte-wide write port, then sets a byte count, then issues a start. The controller hands the stored bytes to the engine one at a time over a valid/ready handshake. It stops when the count is used up or when the engine reports that the far end refused a byte.

For a receive, the controller stores each byte the engine delivers at the next buffer position. For every byte it tells the engine whether to acknowledge it. The count can be set so that the final counted byte is refused. The transfer ends when the count is reached or when the engine sees a STOP.

Every end of a transfer raises an interrupt and loads a status code on the same clock edge. It also holds a clock-stretch request and rewinds the buffer pointer to the first entry, so the host can then read the received bytes, or reload new ones, from the start. A non-buffered mode moves exactly one byte per start.

Top module: `buffered_xfer_ctrl`

## Requirements
- R1: After reset, `irq` and `holdScl` are 0, `txValid` is 0 and `status` reads F8h (the idle code).
- R2: While no transfer runs, a `hostWrEn` pulse stores `hostWrData` at the pointer and advances the pointer. A `hostRdEn` pulse loads `hostRdData` with the entry at the pointer one clock later and advances the pointer. The pointer stops at DEPTH: further writes are dropped, and further reads return entry DEPTH-1.
- R3: The pointer returns to entry 0 on the edge that raises `irq`, on an accepted `start`, and on `irqClear`.
- R4: In buffered mode, a start with a count of 0 or a count above DEPTH moves no byte. It raises `irq` with status FCh on the next edge.
- R5: In a transmit, `txValid` presents the buffer entries in order starting at entry 0. An entry is consumed on an edge with `txValid` and `txReady` high. When the counted number of bytes has been consumed, `irq` rises with status 28h.
- R6: A `nackIn` pulse during a transmit ends it on that edge with status 30h. No further byte is offered.
- R7: In a receive, each `rxValid` stores `rxData` at the pointer. When the counted number of bytes has been stored, `irq` rises with status 50h.
- R8: During a receive, `ackOut` is 1 for every byte, except the final counted byte when the last-byte-refuse bit (`cfgLastNack`) was set; for that byte `ackOut` is 0.
- R9: A `stopIn` pulse during a receive ends it with status A0h, and the bytes stored so far stay readable from entry 0.
- R10: `irq` and `status` change on the same edge. `holdScl` is high exactly while `irq` is high. `irqClear` drops `irq` and returns `status` to F8h. Outside an interrupt, `status` is F8h.
- R11: With `bufMode` low, a start moves exactly one byte whatever the count register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host byte read strobe |
| hostRdData | output | 8 | Byte read at the pointer, valid one clock after the strobe |
| cfgWr | input | 1 | Load count and last-byte-refuse bit |
| cfgCount | input | 7 | Byte count |
| cfgLastNack | input | 1 | Refuse the final counted received byte |
| bufMode | input | 1 | 1 buffered, 0 single byte |
| dirRx | input | 1 | 1 receive, 0 transmit, sampled at start |
| start | input | 1 | Begin a transfer |
| irqClear | input | 1 | Acknowledge the interrupt |
| txValid | output | 1 | A byte is offered to the engine |
| txData | output | 8 | Offered byte |
| txReady | input | 1 | Engine takes the offered byte |
| nackIn | input | 1 | Far end refused the last transmitted byte |
| rxValid | input | 1 | Engine delivers a received byte |
| rxData | input | 8 | Received byte |
| stopIn | input | 1 | STOP seen during a receive |
| ackOut | output | 1 | Acknowledge decision for the byte being received |
| irq | output | 1 | Interrupt |
| status | output | 8 | Status code |
| holdScl | output | 1 | Request to hold the serial clock low |

## Verification
The assertions take for granted that the engine only uses its strobes in the matching direction. That means `txReady` and `nackIn` during a transmit, and `rxValid` and `stopIn` during a receive. They also assume a STOP never arrives together with a data byte, and that the host issues `start` only when no interrupt is pending. The directed stimulus keeps within these assumptions. It changes one strobe at a time on the falling clock edge, and it raises `nackIn` or `stopIn` only in a cycle where the matching data strobe is low. Each scenario clears the interrupt before the next one starts.

// File: rtl/bct_pkg.sv
package bct_pkg;

  localparam logic [7:0] STAT_IDLE    = 8'hF8;
  localparam logic [7:0] STAT_TX_DONE = 8'h28;
  localparam logic [7:0] STAT_TX_NACK = 8'h30;
  localparam logic [7:0] STAT_RX_FULL = 8'h50;
  localparam logic [7:0] STAT_RX_STOP = 8'hA0;
  localparam logic [7:0] STAT_BAD_CNT = 8'hFC;

  // strobes from the sequencer to the buffer datapath
  typedef struct packed {
    logic ptrZero;
    logic ptrInc;
    logic hostWr;
    logic hostRd;
    logic engWr;
    logic cntZero;
    logic cntInc;
  } dpStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_t;

endpackage

// File: rtl/bct_datapath.sv
module bct_datapath
  import bct_pkg::*;
#(
  parameter int DEPTH = 68,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [DW-1:0] hostWrData,
  input  logic [DW-1:0] engRxData,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] cnt,
  output logic [DW-1:0] curByte,
  output logic [DW-1:0] rdData
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptrQ, cntQ;
  logic [AW-1:0] wrIdx, rdIdx;
  logic          room;

  assign room  = ptrQ < FULL_P;
  assign wrIdx = ptrQ[AW-1:0];
  assign rdIdx = room ? ptrQ[AW-1:0] : LAST_IDX;

  // storage: one write per clock, host or engine
  always_ff @(posedge clk) begin
    if (room) begin
      if (stb.hostWr)     mem[wrIdx] <= hostWrData;
      else if (stb.engWr) mem[wrIdx] <= engRxData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ   <= '0;
      cntQ   <= '0;
      rdData <= '0;
    end else begin
      if (stb.ptrZero)             ptrQ <= '0;
      else if (stb.ptrInc && room) ptrQ <= ptrQ + 1'b1;

      if (stb.cntZero)                      cntQ <= '0;
      else if (stb.cntInc && cntQ < FULL_P) cntQ <= cntQ + 1'b1;

      if (stb.hostRd) rdData <= mem[rdIdx];
    end
  end

  assign ptr     = ptrQ;
  assign cnt     = cntQ;
  assign curByte = mem[rdIdx];

endmodule

// File: rtl/bct_control.sv
module bct_control
  import bct_pkg::*;
#(
  parameter int DEPTH = 68,
  parameter int CW    = 7,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic          cfgWr,
  input  logic [CW-1:0] cfgCount,
  input  logic          cfgLastNack,
  input  logic          bufMode,
  input  logic          dirRx,
  input  logic          start,
  input  logic          irqClear,
  input  logic          txReady,
  input  logic          nackIn,
  input  logic          rxValid,
  input  logic          stopIn,
  input  logic [PW-1:0] dpCnt,
  output dpStrobe_t     stb,
  output logic          txValid,
  output logic          ackOut,
  output logic          irq,
  output logic [7:0]    status,
  output logic          busy,
  output logic [CW-1:0] countReg
);

  phase_t        phase;
  logic [CW-1:0] xferCount;
  logic [CW-1:0] effCount;
  logic          lastNackReg;
  logic          badCount, startOk, lastOne, finish;
  logic [7:0]    finCode;

  assign effCount = bufMode ? countReg : CW'(1);
  assign badCount = (effCount == '0) || (int'(effCount) > DEPTH);
  assign startOk  = (phase == PH_IDLE) && start && !irq;
  assign lastOne  = (int'(dpCnt) + 1) == int'(xferCount);
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    stb     = '0;
    txValid = 1'b0;
    ackOut  = 1'b0;
    finish  = 1'b0;
    finCode = STAT_IDLE;
    unique case (phase)
      PH_IDLE: begin
        if (startOk) begin
          stb.ptrZero = 1'b1;
          stb.cntZero = 1'b1;
        end else if (irqClear) begin
          stb.ptrZero = 1'b1;
        end else if (hostWr) begin
          stb.hostWr = 1'b1;
          stb.ptrInc = 1'b1;
        end else if (hostRd) begin
          stb.hostRd = 1'b1;
          stb.ptrInc = 1'b1;
        end
      end
      PH_TX: begin
        txValid = 1'b1;
        if (nackIn) begin
          finish  = 1'b1;
          finCode = STAT_TX_NACK;
        end else if (txReady) begin
          stb.ptrInc = 1'b1;
          stb.cntInc = 1'b1;
          if (lastOne) begin
            finish  = 1'b1;
            finCode = STAT_TX_DONE;
          end
        end
      end
      PH_RX: begin
        ackOut = !(lastNackReg && lastOne);
        if (stopIn) begin
          finish  = 1'b1;
          finCode = STAT_RX_STOP;
        end else if (rxValid) begin
          stb.engWr  = 1'b1;
          stb.ptrInc = 1'b1;
          stb.cntInc = 1'b1;
          if (lastOne) begin
            finish  = 1'b1;
            finCode = STAT_RX_FULL;
          end
        end
      end
      default: ;
    endcase
    if (finish) stb.ptrZero = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      irq         <= 1'b0;
      status      <= STAT_IDLE;
      countReg    <= '0;
      lastNackReg <= 1'b0;
      xferCount   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startOk) begin
            if (badCount) begin
              irq    <= 1'b1;
              status <= STAT_BAD_CNT;
            end else begin
              phase     <= dirRx ? PH_RX : PH_TX;
              xferCount <= effCount;
            end
          end else begin
            if (irqClear) begin
              irq    <= 1'b0;
              status <= STAT_IDLE;
            end
            if (cfgWr) begin
              countReg    <= cfgCount;
              lastNackReg <= cfgLastNack;
            end
          end
        end
        default: begin
          if (finish) begin
            phase  <= PH_IDLE;
            irq    <= 1'b1;
            status <= finCode;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/buffered_xfer_ctrl.sv
module buffered_xfer_ctrl
  import bct_pkg::*;
#(
  parameter int DEPTH = 68,
  parameter int DW    = 8,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [DW-1:0] hostWrData,
  input  logic          hostRdEn,
  output logic [DW-1:0] hostRdData,
  input  logic          cfgWr,
  input  logic [CW-1:0] cfgCount,
  input  logic          cfgLastNack,
  input  logic          bufMode,
  input  logic          dirRx,
  input  logic          start,
  input  logic          irqClear,
  output logic          txValid,
  output logic [DW-1:0] txData,
  input  logic          txReady,
  input  logic          nackIn,
  input  logic          rxValid,
  input  logic [DW-1:0] rxData,
  input  logic          stopIn,
  output logic          ackOut,
  output logic          irq,
  output logic [7:0]    status,
  output logic          holdScl
);

  localparam int PW = $clog2(DEPTH + 1);

  dpStrobe_t     stb;
  logic [PW-1:0] dpPtr, dpCnt;
  logic          ctlBusy;
  logic [CW-1:0] ctlCount;

  bct_control #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_ctl (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWrEn), .hostRd(hostRdEn),
    .cfgWr(cfgWr), .cfgCount(cfgCount), .cfgLastNack(cfgLastNack),
    .bufMode(bufMode), .dirRx(dirRx), .start(start), .irqClear(irqClear),
    .txReady(txReady), .nackIn(nackIn), .rxValid(rxValid), .stopIn(stopIn),
    .dpCnt(dpCnt), .stb(stb), .txValid(txValid), .ackOut(ackOut),
    .irq(irq), .status(status), .busy(ctlBusy), .countReg(ctlCount)
  );

  bct_datapath #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostWrData(hostWrData), .engRxData(rxData),
    .ptr(dpPtr), .cnt(dpCnt), .curByte(txData), .rdData(hostRdData)
  );

  assign holdScl = irq;

endmodule

// File: rtl/buffered_xfer_ctrl_chk.sv
module buffered_xfer_ctrl_chk #(
  parameter int DEPTH = 68,
  parameter int PW    = 7,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          irq,
  input logic [7:0]    status,
  input logic          txValid,
  input logic [PW-1:0] ptr,
  input logic          start,
  input logic          irqClear,
  input logic          busy,
  input logic          bufMode,
  input logic [CW-1:0] countReg
);

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) <= DEPTH); // R2

  AST_REWIND_ON_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ptr == '0); // R3

  AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !irq && bufMode && (countReg == '0 || int'(countReg) > DEPTH))
      |=> (irq && status == 8'hFC && !txValid)); // R4

  AST_NO_TX_IN_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !txValid); // R6

  AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> status != 8'hF8); // R10

  AST_QUIET_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> status == 8'hF8); // R10

  AST_IRQ_DROP_BY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(irqClear)); // R10

endmodule

bind buffered_xfer_ctrl buffered_xfer_ctrl_chk #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .irq(irq), .status(status), .txValid(txValid),
  .ptr(dpPtr), .start(start), .irqClear(irqClear), .busy(ctlBusy),
  .bufMode(bufMode), .countReg(ctlCount)
);

// File: tb/buffered_xfer_ctrl_test.sv
module buffered_xfer_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 0, hostRdEn = 0, cfgWr = 0, cfgLastNack = 0;
  logic [7:0] hostWrData = 0, hostRdData;
  logic [6:0] cfgCount = 0;
  logic       bufMode = 1, dirRx = 0, start = 0, irqClear = 0;
  logic       txValid, txReady = 0, nackIn = 0, rxValid = 0, stopIn = 0;
  logic [7:0] txData, rxData = 0, status;
  logic       ackOut, irq, holdScl;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] got [0:79];
  int nGot;

  always #10 clk = ~clk;

  buffered_xfer_ctrl uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .cfgWr(cfgWr),
    .cfgCount(cfgCount), .cfgLastNack(cfgLastNack), .bufMode(bufMode),
    .dirRx(dirRx), .start(start), .irqClear(irqClear), .txValid(txValid),
    .txData(txData), .txReady(txReady), .nackIn(nackIn), .rxValid(rxValid),
    .rxData(rxData), .stopIn(stopIn), .ackOut(ackOut), .irq(irq),
    .status(status), .holdScl(holdScl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk); hostWrEn = 1; hostWrData = b;
    @(negedge clk); hostWrEn = 0;
  endtask

  task automatic hostRead(output logic [7:0] b);
    @(negedge clk); hostRdEn = 1;
    @(negedge clk); hostRdEn = 0; b = hostRdData;
  endtask

  task automatic setup(input int cnt, input logic lastN, input logic mode);
    @(negedge clk); cfgWr = 1; cfgCount = 7'(cnt); cfgLastNack = lastN; bufMode = mode;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic kick(input logic rx);
    @(negedge clk); dirRx = rx; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClear = 1;
    @(negedge clk); irqClear = 0;
  endtask

  // engine takes every offered byte until the interrupt
  task automatic drainTx();
    int guard = 0;
    nGot = 0;
    txReady = 1;
    while (!irq && guard < 200) begin
      if (txValid) begin got[nGot] = txData; nGot++; end
      @(negedge clk);
      guard++;
    end
    txReady = 0;
  endtask

  task automatic feedRx(input logic [7:0] b, input logic expAck, input string req);
    chk(req, "ackOut", ackOut, expAck);
    rxValid = 1; rxData = b;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic t_reset();
    chk("R1", "irq", irq, 0);
    chk("R1", "holdScl", holdScl, 0);
    chk("R1", "txValid", txValid, 0);
    chk("R1", "status", status, 8'hF8);
  endtask

  task automatic t_tx_basic();
    hostWrite(8'hA1); hostWrite(8'hB2); hostWrite(8'hC3);
    setup(3, 0, 1);
    kick(0);
    drainTx();
    chk("R5", "tx count", nGot, 3);
    chk("R5", "tx byte0", got[0], 8'hA1);
    chk("R5", "tx byte2", got[2], 8'hC3);
    chk("R5", "status", status, 8'h28);
    chk("R10", "holdScl in irq", holdScl, 1);
    clearIrq();
    chk("R10", "irq after clear", irq, 0);
    chk("R10", "status after clear", status, 8'hF8);
    chk("R10", "holdScl after clear", holdScl, 0);
  endtask

  task automatic t_tx_nack();
    logic [7:0] b;
    hostWrite(8'h11); hostWrite(8'h22); hostWrite(8'h33); hostWrite(8'h44);
    setup(4, 0, 1);
    kick(0);
    nGot = 0;
    txReady = 1;
    repeat (2) begin
      if (txValid) begin got[nGot] = txData; nGot++; end
      @(negedge clk);
    end
    txReady = 0; nackIn = 1;
    @(negedge clk); nackIn = 0;
    chk("R6", "irq", irq, 1);
    chk("R6", "status", status, 8'h30);
    chk("R6", "bytes sent", nGot, 2);
    chk("R6", "second byte", got[1], 8'h22);
    @(negedge clk);
    chk("R6", "txValid after nack", txValid, 0);
    hostRead(b);
    chk("R3", "read after irq rewind", b, 8'h11);
    clearIrq();
  endtask

  task automatic t_rx_full();
    logic [7:0] b;
    setup(3, 0, 1);
    kick(1);
    feedRx(8'h5A, 1, "R8");
    feedRx(8'h6B, 1, "R8");
    feedRx(8'h7C, 1, "R8");
    chk("R7", "irq", irq, 1);
    chk("R7", "status", status, 8'h50);
    hostRead(b); chk("R7", "rx byte0", b, 8'h5A);
    hostRead(b); chk("R2", "rx byte1", b, 8'h6B);
    hostRead(b); chk("R2", "rx byte2", b, 8'h7C);
    clearIrq();
  endtask

  task automatic t_rx_lastnack();
    setup(2, 1, 1);
    kick(1);
    feedRx(8'h01, 1, "R8");
    feedRx(8'h02, 0, "R8");
    chk("R8", "status", status, 8'h50);
    clearIrq();
  endtask

  task automatic t_rx_stop();
    logic [7:0] b;
    setup(5, 0, 1);
    kick(1);
    feedRx(8'hD1, 1, "R9");
    feedRx(8'hD2, 1, "R9");
    chk("R9", "no irq mid receive", irq, 0);
    stopIn = 1;
    @(negedge clk); stopIn = 0;
    chk("R9", "irq", irq, 1);
    chk("R9", "status", status, 8'hA0);
    hostRead(b); chk("R9", "first stored", b, 8'hD1);
    clearIrq();
  endtask

  task automatic t_bad_count();
    setup(0, 0, 1);
    kick(0);
    chk("R4", "irq zero count", irq, 1);
    chk("R4", "status zero count", status, 8'hFC);
    chk("R4", "txValid zero count", txValid, 0);
    clearIrq();
    setup(69, 0, 1);
    kick(0);
    chk("R4", "status over count", status, 8'hFC);
    chk("R4", "txValid over count", txValid, 0);
    clearIrq();
  endtask

  task automatic t_byte_mode();
    hostWrite(8'h9A); hostWrite(8'h9B);
    setup(5, 1, 0);
    kick(0);
    drainTx();
    chk("R11", "tx one byte", nGot, 1);
    chk("R11", "tx byte", got[0], 8'h9A);
    chk("R11", "tx status", status, 8'h28);
    clearIrq();
    kick(1);
    feedRx(8'h3C, 0, "R11");
    chk("R11", "rx status", status, 8'h50);
    clearIrq();
  endtask

  task automatic t_saturate();
    logic [7:0] b;
    for (int i = 0; i < 70; i++) hostWrite(8'(i + 1));
    hostRead(b);
    chk("R2", "read at full pointer", b, 68);
    hostRead(b);
    chk("R2", "repeat read at full pointer", b, 68);
    setup(68, 0, 1);
    kick(0);
    drainTx();
    chk("R5", "tx full count", nGot, 68);
    chk("R5", "tx first", got[0], 1);
    chk("R2", "tx last kept", got[67], 68);
    chk("R5", "status", status, 8'h28);
    clearIrq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_nack();
    t_rx_full();
    t_rx_lastnack();
    t_rx_stop();
    t_bad_count();
    t_byte_mode();
    t_saturate();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all-requirements actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule